// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the slave-side protocol engine for a 128-by-8 memory reached over an open-drain two-wire bus. It oversamples the clock and data lines with the core clock, finds start and stop conditions, and collects a first byte that holds a 7-bit word address and a direction bit. For a write it takes data bytes and acknowledges each one. For a read it shifts data bytes out and follows the master's acknowledge on the ninth clock. No device-select byte is used.

Toward the memory side the engine offers a plain byte interface. It provides an address and a one-cycle write strobe with the data. It reads a combinational data input for the current address. It also raises a one-cycle commit pulse when a stop closes a write. A busy input from the storage side makes the engine deaf to the bus. During that time an address byte receives no acknowledge, so the master can poll for the end of a write cycle. The data line is driven only through an active-high pull-down enable.

Top module: `twm_slave`

## Requirements
- R1: After reset `sdaOe`, `memWrEn` and `writeStart` are all 0. Until a start condition has been seen, clocked bytes get no acknowledge.
- R2: A start is a data fall while the clock is high, and a stop is a data rise while the clock is high. A start seen anywhere, including in the middle of a byte, abandons the current transfer and begins a new address phase. A stop returns the engine to idle.
- R3: The first byte after a start is a 7-bit word address, MSB first, followed by a direction bit (1 = read, 0 = write). When not busy, the engine acknowledges it by asserting `sdaOe` for the whole ninth clock.
- R4: Each write data byte (MSB first) is acknowledged on its ninth clock. For each byte, `memWrEn` pulses for exactly one cycle with `memAddr` and `memWrData` valid.
- R5: After each write byte the lower 2 address bits advance by one and wrap within the 4-byte page. The upper 5 bits stay fixed, so a fifth byte overwrites the page's first location.
- R6: A stop that follows at least one received write byte produces exactly one one-cycle `writeStart` pulse. A stop after an address-only write, or after a write that a new start abandoned, produces none.
- R7: While `busy` is high the engine ignores the bus. An address byte gets no acknowledge, and once the busy period is over a fresh start and address byte are acknowledged again.
- R8: In read mode the engine sends the byte at `memAddr`, MSB first, and releases the line during the ninth clock.
- R9: When the master acknowledges a read byte, the next byte comes from the address plus one, wrapping from 127 to 0 over the full 7 bits.
- R10: When the master does not acknowledge a read byte, the engine sends nothing more until the next start or stop.
- R11: `sdaOe` changes only after a detected clock falling edge, or on a start, a stop or busy. It stays constant while the clock is high within a data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, at least 8 times the bus clock rate |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaOe | output | 1 | Pull data line low when 1 |
| busy | input | 1 | Internal write cycle running; bus ignored |
| memAddr | output | 7 | Current word address |
| memWrEn | output | 1 | One-cycle write strobe per received data byte |
| memWrData | output | 8 | Received data byte |
| memRdData | input | 8 | Data stored at `memAddr` (combinational) |
| writeStart | output | 1 | One-cycle pulse: stop closed a write, start the cycle |

## Verification
The main function is tried with a single-byte write to all 128 addresses and a data pattern that varies with the address, followed by one sequential read across the whole array. This combination separates address decoding faults and bit-order faults from stuck data bits. A five-byte burst that starts near a page end shows whether the page wrap keeps the upper address bits. A short read across address 127 shows whether the read counter wraps over all 7 bits. Polling during busy, clocking without a start, a start inside a byte, a write abandoned by a new start, and clocking on after a missing acknowledge each isolate one control path: acknowledge gating, the start and abort handling, commit suppression, and read termination.

// File: rtl/twm_pkg.sv
package twm_pkg;
  localparam int DEF_DATA_W = 8;
  localparam int DEF_PAGE_BITS = 2;
  localparam int DEF_SYNC_STAGES = 2;

  typedef struct packed {
    logic clrCnt;
    logic sampleBit;
    logic latchAddr;
    logic loadOut;
    logic shiftOut;
    logic incPage;
    logic incSeq;
  } dpCtl_t;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_ADDR_ACK, S_WDATA, S_WDATA_ACK, S_RDATA, S_RD_ACK, S_WAIT_STOP
  } engState_t;
endpackage

// File: rtl/twm_sync_edge.sv
module twm_sync_edge #(
  parameter int SYNC_STAGES = twm_pkg::DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  logic [SYNC_STAGES-1:0] sclSh, sdaSh;
  logic sclPrev, sdaPrev, sclNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSh   <= '1;
      sdaSh   <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSh   <= {sclSh[SYNC_STAGES-2:0], sclIn};
      sdaSh   <= {sdaSh[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclSh[SYNC_STAGES-1];
      sdaPrev <= sdaSh[SYNC_STAGES-1];
    end
  end

  assign sclNow   = sclSh[SYNC_STAGES-1];
  assign sdaLvl   = sdaSh[SYNC_STAGES-1];
  assign sclRise  = sclNow & ~sclPrev;
  assign sclFall  = ~sclNow & sclPrev;
  assign startDet = sclNow & sclPrev & sdaPrev & ~sdaLvl;
  assign stopDet  = sclNow & sclPrev & ~sdaPrev & sdaLvl;
endmodule

// File: rtl/twm_datapath.sv
module twm_datapath
  import twm_pkg::*;
#(
  parameter int DATA_W    = DEF_DATA_W,
  parameter int PAGE_BITS = DEF_PAGE_BITS,
  localparam int ADDR_W   = DATA_W - 1,
  localparam int CNT_W    = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              sdaLvl,
  input  logic [DATA_W-1:0] memRdData,
  output logic              byteFull,
  output logic              rwBit,
  output logic              txMsb,
  output logic [ADDR_W-1:0] addrOut,
  output logic [DATA_W-1:0] rxByte
);
  logic [DATA_W-1:0] rxShift, txShift;
  logic [CNT_W-1:0]  bitCnt;
  logic [ADDR_W-1:0] addrReg;
  logic              rwReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      bitCnt  <= '0;
    end else if (ctl.clrCnt) begin
      bitCnt  <= '0;
    end else if (ctl.sampleBit) begin
      rxShift <= {rxShift[DATA_W-2:0], sdaLvl};
      bitCnt  <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      rwReg   <= 1'b0;
    end else if (ctl.latchAddr) begin
      addrReg <= rxShift[DATA_W-1:1];
      rwReg   <= rxShift[0];
    end else if (ctl.incSeq) begin
      addrReg <= addrReg + 1'b1;
    end else if (ctl.incPage) begin
      addrReg[PAGE_BITS-1:0] <= addrReg[PAGE_BITS-1:0] + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             txShift <= '1;
    else if (ctl.loadOut)  txShift <= memRdData;
    else if (ctl.shiftOut) txShift <= {txShift[DATA_W-2:0], 1'b1};
  end

  assign byteFull = (bitCnt == CNT_W'(DATA_W));
  assign rwBit    = rwReg;
  assign txMsb    = txShift[DATA_W-1];
  assign addrOut  = addrReg;
  assign rxByte   = rxShift;
endmodule

// File: rtl/twm_ctrl.sv
module twm_ctrl
  import twm_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   sclRise,
  input  logic   sclFall,
  input  logic   startDet,
  input  logic   stopDet,
  input  logic   sdaLvl,
  input  logic   busy,
  input  logic   byteFull,
  input  logic   rwBit,
  input  logic   txMsb,
  output dpCtl_t ctl,
  output logic   sdaOe,
  output logic   memWrEn,
  output logic   writeStart
);
  engState_t state, stateNxt;
  logic wrPending, pendNxt, ackSeen, ackNxt, wrEnNxt, wsNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      wrPending  <= 1'b0;
      ackSeen    <= 1'b0;
      memWrEn    <= 1'b0;
      writeStart <= 1'b0;
    end else begin
      state      <= stateNxt;
      wrPending  <= pendNxt;
      ackSeen    <= ackNxt;
      memWrEn    <= wrEnNxt;
      writeStart <= wsNxt;
    end
  end

  always_comb begin
    stateNxt = state;
    pendNxt  = wrPending;
    ackNxt   = ackSeen;
    wrEnNxt  = 1'b0;
    wsNxt    = 1'b0;
    ctl      = '0;
    if (busy) begin
      stateNxt = S_IDLE;
      pendNxt  = 1'b0;
    end else if (stopDet) begin
      stateNxt = S_IDLE;
      wsNxt    = wrPending;
      pendNxt  = 1'b0;
    end else if (startDet) begin
      stateNxt   = S_ADDR;
      ctl.clrCnt = 1'b1;
      pendNxt    = 1'b0;
    end else begin
      unique case (state)
        S_ADDR: begin
          if (sclRise && !byteFull) ctl.sampleBit = 1'b1;
          else if (sclFall && byteFull) begin
            ctl.latchAddr = 1'b1;
            stateNxt      = S_ADDR_ACK;
          end
        end
        S_ADDR_ACK: begin
          if (sclFall) begin
            ctl.clrCnt = 1'b1;
            if (rwBit) begin
              ctl.loadOut = 1'b1;
              stateNxt    = S_RDATA;
            end else begin
              stateNxt    = S_WDATA;
            end
          end
        end
        S_WDATA: begin
          if (sclRise && !byteFull) ctl.sampleBit = 1'b1;
          else if (sclFall && byteFull) begin
            wrEnNxt  = 1'b1;
            pendNxt  = 1'b1;
            stateNxt = S_WDATA_ACK;
          end
        end
        S_WDATA_ACK: begin
          if (sclFall) begin
            ctl.clrCnt  = 1'b1;
            ctl.incPage = 1'b1;
            stateNxt    = S_WDATA;
          end
        end
        S_RDATA: begin
          if (sclRise && !byteFull) ctl.sampleBit = 1'b1;
          else if (sclFall) begin
            if (byteFull) stateNxt = S_RD_ACK;
            else          ctl.shiftOut = 1'b1;
          end
        end
        S_RD_ACK: begin
          if (sclRise) begin
            ackNxt     = !sdaLvl;
            ctl.incSeq = !sdaLvl;
          end else if (sclFall) begin
            if (ackSeen) begin
              ctl.clrCnt  = 1'b1;
              ctl.loadOut = 1'b1;
              stateNxt    = S_RDATA;
            end else begin
              stateNxt    = S_WAIT_STOP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sdaOe = (state == S_ADDR_ACK) || (state == S_WDATA_ACK) ||
                 ((state == S_RDATA) && !txMsb);
endmodule

// File: rtl/twm_slave.sv
module twm_slave
  import twm_pkg::*;
#(
  parameter int DATA_W      = DEF_DATA_W,
  parameter int PAGE_BITS   = DEF_PAGE_BITS,
  parameter int SYNC_STAGES = DEF_SYNC_STAGES,
  localparam int ADDR_W     = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  input  logic              busy,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWrEn,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData,
  output logic              writeStart
);
  logic   sdaLvl, sclRise, sclFall, startDet, stopDet;
  logic   byteFull, rwBit, txMsb;
  dpCtl_t dpCtl;

  twm_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .sdaLvl(sdaLvl),
    .sclRise(sclRise), .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet)
  );

  twm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaLvl(sdaLvl), .busy(busy),
    .byteFull(byteFull), .rwBit(rwBit), .txMsb(txMsb), .ctl(dpCtl),
    .sdaOe(sdaOe), .memWrEn(memWrEn), .writeStart(writeStart)
  );

  twm_datapath #(.DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(dpCtl), .sdaLvl(sdaLvl), .memRdData(memRdData),
    .byteFull(byteFull), .rwBit(rwBit), .txMsb(txMsb), .addrOut(memAddr),
    .rxByte(memWrData)
  );
endmodule

// File: rtl/twm_slave_chk.sv
module twm_slave_chk
  import twm_pkg::*;
#(
  parameter int DATA_W    = DEF_DATA_W,
  parameter int PAGE_BITS = DEF_PAGE_BITS,
  localparam int ADDR_W   = DATA_W - 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              sdaOe,
  input logic              busy,
  input logic              memWrEn,
  input logic              writeStart,
  input logic [ADDR_W-1:0] memAddr,
  input logic              sclFall,
  input logic              startDet,
  input logic              stopDet,
  input dpCtl_t            ctl
);
  // R11: pull-down changes only in response to a clock fall, start, stop or busy
  a_r11_oe_after_fall: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe != $past(sdaOe)) |-> $past(sclFall || startDet || stopDet || busy));

  // R7: a busy engine never pulls the line
  a_r7_busy_silent: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> !sdaOe);

  // R6: commit pulse only right after a stop
  a_r6_commit_on_stop: assert property (@(posedge clk) disable iff (!rstN)
    writeStart |-> $past(stopDet));

  // R6: commit pulse lasts one cycle
  a_r6_commit_pulse: assert property (@(posedge clk) disable iff (!rstN)
    writeStart |=> !writeStart);

  // R4: write strobe lasts one cycle and never coincides with a commit
  a_r4_wr_pulse: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |=> !memWrEn);
  a_r4_wr_not_commit: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memWrEn, writeStart}));

  // R5: page step keeps the upper bits and advances the lower ones
  a_r5_page_wrap: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.incPage) |->
      (memAddr[ADDR_W-1:PAGE_BITS] == $past(memAddr[ADDR_W-1:PAGE_BITS])) &&
      (memAddr[PAGE_BITS-1:0] == PAGE_BITS'($past(memAddr[PAGE_BITS-1:0]) + 1'b1)));

  // R9: sequential read step covers all address bits
  a_r9_seq_wrap: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.incSeq) |-> (memAddr == ADDR_W'($past(memAddr) + 1'b1)));
endmodule

bind twm_slave twm_slave_chk #(.DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .sdaOe(sdaOe), .busy(busy), .memWrEn(memWrEn),
  .writeStart(writeStart), .memAddr(memAddr), .sclFall(sclFall),
  .startDet(startDet), .stopDet(stopDet), .ctl(dpCtl)
);

// File: tb/twm_slave_bench.sv
module twm_slave_bench;
  localparam int Q = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic sdaOe, memWrEn, writeStart, busy, sdaLine;
  logic [6:0] memAddr;
  logic [7:0] memWrData, memRdData;
  logic [7:0] mem [128];
  logic [7:0] expMem [128];
  int busyCnt = 0;
  int nChk = 0, nFail = 0, wsCount = 0;
  bit doneFlag = 0;

  always #10 clk = ~clk;

  assign sdaLine   = mSda & ~sdaOe;
  assign memRdData = mem[memAddr];
  assign busy      = (busyCnt != 0);

  twm_slave u_twm_slave (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .busy(busy), .memAddr(memAddr), .memWrEn(memWrEn), .memWrData(memWrData),
    .memRdData(memRdData), .writeStart(writeStart)
  );

  always @(posedge clk) begin
    if (memWrEn) mem[memAddr] <= memWrData;
    if (writeStart) begin
      wsCount <= wsCount + 1;
      busyCnt <= 60;
    end else if (busyCnt != 0) begin
      busyCnt <= busyCnt - 1;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input int act, input int expv);
    nChk++;
    if (act != expv) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic startCond();
    mSda = 1'b1; tick(Q);
    mScl = 1'b1; tick(Q);
    mSda = 1'b0; tick(Q);
    mScl = 1'b0;
  endtask

  task automatic stopCond();
    tick(Q); mSda = 1'b0; tick(Q);
    mScl = 1'b1; tick(Q);
    mSda = 1'b1; tick(Q);
  endtask

  task automatic sendBit(input logic b);
    tick(Q); mSda = b; tick(Q);
    mScl = 1'b1; tick(2*Q);
    mScl = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    tick(Q); mSda = 1'b1; tick(Q);
    mScl = 1'b1; tick(Q);
    ack = !sdaLine; tick(Q);
    mScl = 1'b0;
  endtask

  task automatic readByte(input logic ackIt, output logic [7:0] v, output logic stable);
    logic b;
    stable = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); mSda = 1'b1; tick(Q);
      mScl = 1'b1; tick(Q);
      b = sdaLine; tick(Q);
      if (sdaLine != b) stable = 1'b0;
      v[i] = b;
      mScl = 1'b0;
    end
    tick(Q); mSda = ackIt ? 1'b0 : 1'b1; tick(Q);
    mScl = 1'b1; tick(2*Q);
    mScl = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) tick(1);
    tick(2);
  endtask

  initial begin
    logic ack, stable;
    logic [7:0] v, d;
    int ws0;
    for (int i = 0; i < 128; i++) begin mem[i] = 8'h00; expMem[i] = 8'h00; end
    tick(3);
    // R1: reset state
    chk("R1 reset sdaOe", int'(sdaOe), 0);
    chk("R1 reset memWrEn", int'(memWrEn), 0);
    chk("R1 reset writeStart", int'(writeStart), 0);
    rstN = 1'b1; tick(4);

    // R1: bytes without a start are not acknowledged
    mScl = 1'b0; tick(Q);
    sendByte(8'h00, ack);
    chk("R1 no start no ack", int'(ack), 0);
    sendByte(8'h42, ack);
    chk("R1 no start no ack 2", int'(ack), 0);
    stopCond();

    // R3 R4 R6: single-byte write to every address
    for (int a = 0; a < 128; a++) begin
      waitIdle();
      d = 8'((a * 37 + 11) & 255);
      ws0 = wsCount;
      startCond();
      sendByte({7'(a), 1'b0}, ack);
      chk("R3 write addr ack", int'(ack), 1);
      sendByte(d, ack);
      chk("R4 write data ack", int'(ack), 1);
      stopCond();
      expMem[a] = d;
      chk("R6 commit after write", wsCount - ws0, 1);
    end

    // R8: sequential read of the whole array
    waitIdle();
    startCond();
    sendByte({7'd0, 1'b1}, ack);
    chk("R3 read addr ack", int'(ack), 1);
    for (int a = 0; a < 128; a++) begin
      readByte(a != 127, v, stable);
      chk("R8 read data", int'(v), int'(expMem[a]));
      if (a % 32 == 0) chk("R11 stable while scl high", int'(stable), 1);
    end
    stopCond();

    // R5: five bytes starting at 0x1D wrap inside page 0x1C..0x1F
    waitIdle();
    startCond();
    sendByte({7'h1D, 1'b0}, ack);
    for (int k = 0; k < 5; k++) begin
      sendByte(8'hA0 + 8'(k), ack);
      chk("R5 page byte ack", int'(ack), 1);
    end
    stopCond();
    expMem[7'h1D] = 8'hA4; expMem[7'h1E] = 8'hA1;
    expMem[7'h1F] = 8'hA2; expMem[7'h1C] = 8'hA3;
    waitIdle();
    startCond();
    sendByte({7'h1B, 1'b1}, ack);
    for (int a = 8'h1B; a <= 8'h20; a++) begin
      readByte(a != 8'h20, v, stable);
      chk("R5 page content", int'(v), int'(expMem[a]));
    end
    stopCond();

    // R9: sequential read wraps 127 -> 0
    waitIdle();
    startCond();
    sendByte({7'h7E, 1'b1}, ack);
    for (int k = 0; k < 4; k++) begin
      readByte(k != 3, v, stable);
      chk("R9 read wrap", int'(v), int'(expMem[(8'h7E + k) % 128]));
    end
    stopCond();

    // R10: after a missing acknowledge the line stays released
    waitIdle();
    startCond();
    sendByte({7'h05, 1'b1}, ack);
    readByte(1'b0, v, stable);
    chk("R10 first byte", int'(v), int'(expMem[5]));
    readByte(1'b0, v, stable);
    chk("R10 released after nack", int'(v), 8'hFF);
    stopCond();

    // R7: polling during busy gets no acknowledge, later it does
    waitIdle();
    startCond();
    sendByte({7'h30, 1'b0}, ack);
    sendByte(8'h5A, ack);
    stopCond();
    expMem[7'h30] = 8'h5A;
    chk("R7 busy raised", int'(busy), 1);
    startCond();
    sendByte({7'h30, 1'b0}, ack);
    chk("R7 no ack while busy", int'(ack), 0);
    stopCond();
    waitIdle();
    ws0 = wsCount;
    startCond();
    sendByte({7'h30, 1'b0}, ack);
    chk("R7 ack after busy", int'(ack), 1);
    stopCond();
    chk("R6 no commit without data", wsCount - ws0, 0);

    // R2: start inside a byte abandons it and starts a new address phase
    waitIdle();
    startCond();
    for (int i = 7; i >= 4; i--) sendBit(v[i]);
    startCond();
    sendByte({7'h30, 1'b1}, ack);
    chk("R2 ack after abort", int'(ack), 1);
    readByte(1'b0, v, stable);
    chk("R2 read after abort", int'(v), int'(expMem[7'h30]));
    stopCond();

    // R6: write abandoned by a new start is not committed
    waitIdle();
    ws0 = wsCount;
    startCond();
    sendByte({7'h40, 1'b0}, ack);
    sendByte(8'hC3, ack);
    chk("R4 data ack before abort", int'(ack), 1);
    startCond();
    stopCond();
    tick(4);
    chk("R6 no commit after abort", wsCount - ws0, 0);
    chk("R2 idle after stop", int'(sdaOe), 0);

    if (!doneFlag) begin
      doneFlag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!doneFlag) begin
      doneFlag = 1;
      nChk++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end
endmodule